// File: doc/BRIEF.md
# General-purpose pin function and output register block

This block is a word-addressed register file that configures a row of general-purpose pins. The default is 54 pins. Each pin has a 3-bit function code. The code picks plain input, driven output, or one of six alternate functions. The codes are packed ten to a 32-bit word. The block turns each code into an output enable and into an alternate-function index for the pad multiplexer outside it.

Output values sit in one latch per pin. Software changes these latches only through a write-one-to-set register and a write-one-to-clear register. Each of those registers spans 32-bit banks. Because of this, two agents can update different pins without a read-modify-write race. A read-only register returns the pin levels after a two-flop synchroniser.

The bus uses word addresses, which are the byte offset divided by four. Each word address maps as follows:

| Registers | Word addresses | Byte offsets |
|---|---|---|
| Select words | 0–5 | 0x00–0x14 |
| Set banks | 7–8 | 0x1C, 0x20 |
| Clear banks | 10–11 | 0x28, 0x2C |
| Level banks | 13–14 | 0x34, 0x38 |

Read data is registered. It appears one clock after the read strobe and is zero in any cycle that follows a clock with no read.

Top module: `pin_ctrl_regs`

## Requirements
- R1: Reset (synchronous, active-high `rst`) sets every function code to 0 (input) and every output latch to 0. So after reset `pin_out` and `pin_oe` are all zero, every `pin_alt` field is 7, and every select word reads 0.
- R2: Pin p's function code is stored in select word p/10, at bits (p%10)*3+2 down to (p%10)*3. A write to a select word replaces all ten fields in it, and reading the word back returns them in the same positions.
- R3: Select-word bits 30–31 read as zero. Fields of select word 5 that belong to no pin (pin numbers 54 and up) read as zero even after all ones have been written.
- R4: A write to set bank b (word 7+b) drives the latch of pin 32*b+i to 1 for every data bit i that is 1. Bits written as 0 leave their latches unchanged.
- R5: A write to clear bank b (word 10+b) drives the latch of pin 32*b+i to 0 for every data bit i that is 1. Bits written as 0 leave their latches unchanged.
- R6: `pin_oe[p]` is 1 exactly when pin p's function code is 1. Codes 0 and 2–7 give 0.
- R7: `pin_alt[3p+2:3p]` maps pin p's code as follows:

  | Code | `pin_alt` value |
  |---|---|
  | 4 | 0 |
  | 5 | 1 |
  | 6 | 2 |
  | 7 | 3 |
  | 3 | 4 |
  | 2 | 5 |
  | 0 or 1 (plain input or output) | 7 |

- R8: `pin_out` always shows the output latch, whatever the function code. A value set while a pin is in input mode is driven as soon as its code becomes 1, with no further set write.
- R9: Level bank b (word 13+b) returns the level of pin 32*b+i in bit i, after two synchroniser flops. Reads in the first two clocks after an input change still return the old level, and the third read returns the new one. Bits above pin 53 read as zero.
- R10: `bus_rdata` holds the addressed word in the cycle after `bus_rd`, and is zero after a cycle without `bus_rd`. The following read as zero: set banks, clear banks, and unmapped words (6, 9, 12, 15 and up). Writes to level banks or unmapped words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe; data follows one cycle later |
| bus_addr | input | ADDR_W (5) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS (54) | Raw pin levels from the pads |
| pin_out | output | NUM_PINS (54) | Output latch value per pin |
| pin_oe | output | NUM_PINS (54) | Output enable per pin |
| pin_alt | output | 3*NUM_PINS (162) | Alternate-function index per pin, 7 when none |

## Verification
Several corner cases are targeted:
- **Scrambled code table.** The bench walks every function code through the decoder. A straight code-minus-four mapping would show up at codes 2 and 3.
- **Set and clear with zero bits.** It writes all-zero and sparse set and clear words. A design that copied the data word into the latches would wipe pins that were never addressed.
- **Padding of the top select word.** It fills the top select word with ones and reads it back. Storing the unused fields or bits 30–31 would leak ones into the read data.
- **Synchroniser latency.** It checks the level reads right after an input edge. One synchroniser stage too few or too many moves the first read that shows the new level.
- **Latch kept across a function change.** It sets a latch while its pin is an input. A latch cleared on a function change would fail when the pin then turns to output.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

  localparam int WORD_W          = 32;
  localparam int CODE_W          = 3;
  localparam int FIELDS_PER_WORD = 10;

  // word addresses (byte offset / 4); software layout depends on these
  localparam int SEL_BASE = 0;
  localparam int SET_BASE = 7;
  localparam int CLR_BASE = 10;
  localparam int LVL_BASE = 13;

  typedef enum logic [CODE_W-1:0] {
    FN_INPUT  = 3'd0,
    FN_OUTPUT = 3'd1,
    FN_ALT_F  = 3'd2,
    FN_ALT_E  = 3'd3,
    FN_ALT_A  = 3'd4,
    FN_ALT_B  = 3'd5,
    FN_ALT_C  = 3'd6,
    FN_ALT_D  = 3'd7
  } pin_fn_e;

  localparam logic [CODE_W-1:0] NO_ALT = 3'd7;

  function automatic logic [CODE_W-1:0] alt_index(input logic [CODE_W-1:0] code);
    case (pin_fn_e'(code))
      FN_ALT_A: alt_index = 3'd0;
      FN_ALT_B: alt_index = 3'd1;
      FN_ALT_C: alt_index = 3'd2;
      FN_ALT_D: alt_index = 3'd3;
      FN_ALT_E: alt_index = 3'd4;
      FN_ALT_F: alt_index = 3'd5;
      default:  alt_index = NO_ALT;
    endcase
  endfunction

endpackage

// File: rtl/pcr_sync.sv
module pcr_sync #(
  parameter int W = 54
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pcr_func_sel.sv
module pcr_func_sel
  import pcr_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_idx,
  input  logic [WORD_W-1:0]          wdata,
  input  logic [ADDR_W-1:0]          rd_idx,
  output logic [WORD_W-1:0]          rd_word,
  output logic [NUM_PINS*CODE_W-1:0] codes
);
  always_ff @(posedge clk) begin
    if (rst) begin
      codes <= '0;
    end else if (wr_en) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (wr_idx == ADDR_W'(SEL_BASE + p / FIELDS_PER_WORD))
          codes[p*CODE_W +: CODE_W] <= wdata[(p % FIELDS_PER_WORD)*CODE_W +: CODE_W];
      end
    end
  end

  // only fields backed by a pin are placed; padding stays zero
  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (rd_idx == ADDR_W'(SEL_BASE + p / FIELDS_PER_WORD))
        rd_word[(p % FIELDS_PER_WORD)*CODE_W +: CODE_W] = codes[p*CODE_W +: CODE_W];
    end
  end
endmodule

// File: rtl/pcr_out_latch.sv
module pcr_out_latch
  import pcr_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int BANKS    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BANKS-1:0]    set_hit,
  input  logic [BANKS-1:0]    clr_hit,
  input  logic [WORD_W-1:0]   wdata,
  output logic [NUM_PINS-1:0] latch_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
    end else begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (set_hit[p / WORD_W] && wdata[p % WORD_W])
          latch_q[p] <= 1'b1;
        else if (clr_hit[p / WORD_W] && wdata[p % WORD_W])
          latch_q[p] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pin_ctrl_regs.sv
module pin_ctrl_regs
  import pcr_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [NUM_PINS-1:0]        pin_in,
  output logic [NUM_PINS-1:0]        pin_out,
  output logic [NUM_PINS-1:0]        pin_oe,
  output logic [NUM_PINS*CODE_W-1:0] pin_alt
);
  localparam int BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int PAD_W = BANKS * WORD_W;

  logic [NUM_PINS*CODE_W-1:0] codes;
  logic [WORD_W-1:0]          sel_word;
  logic [BANKS-1:0]           set_hit, clr_hit;
  logic [NUM_PINS-1:0]        lvl_sync;
  logic [PAD_W-1:0]           lvl_pad;
  logic [WORD_W-1:0]          rd_next;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign set_hit[b] = bus_wr && (bus_addr == ADDR_W'(SET_BASE + b));
    assign clr_hit[b] = bus_wr && (bus_addr == ADDR_W'(CLR_BASE + b));
  end

  pcr_func_sel #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr),
    .wr_idx  (bus_addr),
    .wdata   (bus_wdata),
    .rd_idx  (bus_addr),
    .rd_word (sel_word),
    .codes   (codes)
  );

  pcr_out_latch #(.NUM_PINS(NUM_PINS), .BANKS(BANKS)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .set_hit (set_hit),
    .clr_hit (clr_hit),
    .wdata   (bus_wdata),
    .latch_q (pin_out)
  );

  pcr_sync #(.W(NUM_PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (lvl_sync)
  );

  always_comb begin
    lvl_pad                 = '0;
    lvl_pad[NUM_PINS-1:0]   = lvl_sync;
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr < ADDR_W'(SEL_BASE + (NUM_PINS + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD))
      rd_next = sel_word;
    for (int b = 0; b < BANKS; b++) begin
      if (bus_addr == ADDR_W'(LVL_BASE + b))
        rd_next = lvl_pad[b*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
    else             bus_rdata <= '0;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pin_oe[p] = (codes[p*CODE_W +: CODE_W] == FN_OUTPUT);
    assign pin_alt[p*CODE_W +: CODE_W] = alt_index(codes[p*CODE_W +: CODE_W]);
  end
endmodule

// File: rtl/pin_ctrl_regs_chk.sv
module pin_ctrl_regs_chk #(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [31:0]           bus_wdata,
  input logic [31:0]           bus_rdata,
  input logic [NUM_PINS-1:0]   pin_out,
  input logic [NUM_PINS-1:0]   pin_oe,
  input logic [NUM_PINS*3-1:0] pin_alt
);
  localparam int BANKS = (NUM_PINS + 31) / 32;
  localparam int SELW  = (NUM_PINS + 9) / 10;
  localparam int LOW_W = (NUM_PINS < 32) ? NUM_PINS : 32;

  logic latch_wr, sel_wr, set0_wr, clr0_wr;
  assign set0_wr  = bus_wr && (bus_addr == ADDR_W'(pcr_pkg::SET_BASE));
  assign clr0_wr  = bus_wr && (bus_addr == ADDR_W'(pcr_pkg::CLR_BASE));
  assign sel_wr   = bus_wr && (bus_addr < ADDR_W'(pcr_pkg::SEL_BASE + SELW));
  assign latch_wr = bus_wr &&
    ((bus_addr >= ADDR_W'(pcr_pkg::SET_BASE) && bus_addr < ADDR_W'(pcr_pkg::SET_BASE + BANKS)) ||
     (bus_addr >= ADDR_W'(pcr_pkg::CLR_BASE) && bus_addr < ADDR_W'(pcr_pkg::CLR_BASE + BANKS)));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0));

  // R4
  set_bits_chk: assert property (@(posedge clk) disable iff (rst)
    set0_wr |=> ((pin_out[LOW_W-1:0] & $past(bus_wdata[LOW_W-1:0])) == $past(bus_wdata[LOW_W-1:0])));

  // R5
  clear_bits_chk: assert property (@(posedge clk) disable iff (rst)
    clr0_wr |=> ((pin_out[LOW_W-1:0] & $past(bus_wdata[LOW_W-1:0])) == '0));

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !latch_wr |=> $stable(pin_out));

  // R6
  func_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_wr |=> ($stable(pin_oe) && $stable(pin_alt)));

  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

bind pin_ctrl_regs pin_ctrl_regs_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pin_alt   (pin_alt)
);

// File: tb/pin_ctrl_regs_tb.sv
`timescale 1ns/1ps
module pin_ctrl_regs_tb;
  localparam int NP = 54;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  logic [NP*3-1:0] pin_alt;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } rd_item_t;
  rd_item_t rd_q[$];

  always #10 clk = ~clk;

  pin_ctrl_regs #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_alt(pin_alt)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver tasks: enter and leave on a falling edge
  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    rd_q.push_back(it);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [2:0] alt_of(input int p);
    return pin_alt[p*3 +: 3];
  endfunction

  // monitor: pops one expected item per read strobe
  initial begin
    forever begin
      logic took;
      @(posedge clk);
      took = bus_rd;
      @(negedge clk);
      if (took) begin
        rd_item_t it;
        if (rd_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R10: read data with no expected item, actual %h expected none", bus_rdata);
        end else begin
          it = rd_q.pop_front();
          chk(64'(bus_rdata), 64'(it.exp), it.tag);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] exp_out;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(64'(pin_out), 64'(0), "R1 pin_out");
    chk(64'(pin_oe),  64'(0), "R1 pin_oe");
    chk(64'(alt_of(0)),  64'(7), "R1 alt pin0");
    chk(64'(alt_of(53)), 64'(7), "R1 alt pin53");
    rd(0, 32'h0, "R1 sel word0");
    rd(5, 32'h0, "R1 sel word5");

    // R2 field placement: pin10=1, pin13=4, pin19=6
    wr(1, (32'd1 << 0) | (32'd4 << 9) | (32'd6 << 27));
    rd(1, (32'd1 << 0) | (32'd4 << 9) | (32'd6 << 27), "R2 word1 readback");
    chk(64'(pin_oe), 64'(54'h400), "R6 only pin10 enabled");
    // R7 scrambled decode
    chk(64'(alt_of(10)), 64'(7), "R7 code1 no alt");
    chk(64'(alt_of(13)), 64'(0), "R7 code4");
    chk(64'(alt_of(19)), 64'(2), "R7 code6");
    wr(2, (32'd2 << 0) | (32'd3 << 3) | (32'd5 << 6) | (32'd7 << 9));
    chk(64'(alt_of(20)), 64'(5), "R7 code2");
    chk(64'(alt_of(21)), 64'(4), "R7 code3");
    chk(64'(alt_of(22)), 64'(1), "R7 code5");
    chk(64'(alt_of(23)), 64'(3), "R7 code7");
    chk(64'(alt_of(24)), 64'(7), "R7 code0");

    // R3 padding bits
    wr(5, 32'hFFFF_FFFF);
    rd(5, 32'h0000_0FFF, "R3 word5 partial");
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h3FFF_FFFF, "R3 word0 top bits");
    chk(64'(pin_oe), 64'(54'h400), "R6 code7 not enabled");

    // R6 output enable only for code 1
    wr(0, 32'h0924_9249);
    chk(64'(pin_oe), 64'(54'h7FF), "R6 pins0-10 enabled");
    wr(0, 32'h0);
    chk(64'(pin_oe), 64'(54'h400), "R6 disabled again");

    // R4 set
    wr(7, 32'h8000_0011);
    exp_out = {22'h0, 32'h8000_0011};
    chk(64'(pin_out), 64'(exp_out), "R4 set bank0");
    wr(8, 32'hFFFF_FFFF);
    exp_out = {22'h3F_FFFF, 32'h8000_0011};
    chk(64'(pin_out), 64'(exp_out), "R4 set bank1");
    wr(7, 32'h0);
    chk(64'(pin_out), 64'(exp_out), "R4 zero set no effect");
    rd(7, 32'h0, "R10 set reads zero");

    // R8 latch survives function change
    chk(64'({pin_out[4], pin_oe[4]}), 64'(2'b10), "R8 latch while input");
    wr(0, 32'd1 << 12);
    chk(64'({pin_out[4], pin_oe[4]}), 64'(2'b11), "R8 driven on switch");
    chk(64'(pin_out), 64'(exp_out), "R8 latches unchanged");

    // R5 clear
    wr(10, 32'h0000_0001);
    exp_out = {22'h3F_FFFF, 32'h8000_0010};
    chk(64'(pin_out), 64'(exp_out), "R5 clear bank0");
    wr(11, 32'h0020_0000);
    exp_out = {22'h1F_FFFF, 32'h8000_0010};
    chk(64'(pin_out), 64'(exp_out), "R5 clear pin53");
    wr(11, 32'h0);
    chk(64'(pin_out), 64'(exp_out), "R5 zero clear no effect");
    rd(10, 32'h0, "R10 clear reads zero");

    // R9 level read and synchroniser latency
    pin_in = {22'h2A_5A5C, 32'h1234_ABCD};
    @(negedge clk); @(negedge clk); @(negedge clk);
    rd(13, 32'h1234_ABCD, "R9 level bank0");
    rd(14, 32'h002A_5A5C, "R9 level bank1 padded");
    pin_in = {22'h0, 32'h0000_00F0};
    rd(13, 32'h1234_ABCD, "R9 first read old");
    rd(13, 32'h1234_ABCD, "R9 second read old");
    rd(13, 32'h0000_00F0, "R9 third read new");

    // R10 read-only and unmapped
    wr(13, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF);
    wr(15, 32'hFFFF_FFFF);
    chk(64'(pin_out), 64'(exp_out), "R10 ignored writes keep latches");
    chk(64'(pin_oe), 64'(54'h410), "R10 ignored writes keep functions");
    rd(13, 32'h0000_00F0, "R10 level not writable");
    rd(6, 32'h0, "R10 unmapped 6");
    rd(15, 32'h0, "R10 unmapped 15");
    @(negedge clk);
    chk(64'(bus_rdata), 64'(0), "R10 idle rdata zero");

    repeat (3) @(negedge clk);
    chk(64'(rd_q.size()), 64'(0), "R10 all reads answered");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule